// File: doc/BRIEF.md
# USB Host Bus-State Sequencer

This block decides, cycle by cycle, whether a USB host is running, suspended, or driving resume or reset signalling on the bus. Software controls it with three bits: suspend, resume and reset. A busy flag tells it that a transaction is in flight, and a millisecond tick lets it time the signalling intervals. Its outputs enable the frame counter and transaction scheduler and the start-of-frame generator. It also requests the resume or reset line drive from the analog front end.

A suspend request takes effect only once the current transaction has finished. Resume or reset signalling lasts exactly as long as software holds the matching bit. Normal operation restarts in the cycle after software clears that bit. Each signalling interval is timed in milliseconds against a minimum of `MIN_MS`, and a status flag reports whether the last interval was too short. A rising edge on the remote wake-up detector while suspended produces a single-cycle interrupt. It leaves the bus state unchanged; software decides whether to resume.

Top module: `host_bus_seq`

## Requirements
- R1: After reset, schedEnable and sofEnable are 1 and driveResume, driveReset, wakeIrq and timingViolation are 0.
- R2: When suspendBit is 1 and xferBusy is 0 in a running cycle, schedEnable and sofEnable are 0 from the next cycle on.
- R3: While suspendBit and xferBusy are both 1, schedEnable stays 1. The stop happens in the cycle after the first cycle in which xferBusy is 0.
- R4: While suspended with suspendBit still 1, schedEnable, sofEnable and driveResume stay 0 whatever resumeBit does.
- R5: When suspended, resumeBit = 1 with suspendBit = 0 raises driveResume in the next cycle. driveResume stays 1 for as long as resumeBit is 1, and schedEnable stays 0 meanwhile.
- R6: When resumeBit is cleared during resume signalling, driveResume falls and schedEnable and sofEnable rise in the next cycle.
- R7: resetBit = 1 raises driveReset in the next cycle from any state and takes priority over suspendBit and resumeBit. While driveReset is 1, schedEnable is 0.
- R8: When resetBit is cleared during reset signalling, driveReset falls and schedEnable and sofEnable rise in the next cycle.
- R9: A signalling interval counts the msTick pulses seen while the signalling is held. When the interval ends, timingViolation is set to 1 if fewer than MIN_MS pulses were counted and to 0 otherwise. It holds that value until the next interval ends.
- R10: A 0-to-1 change of wakeDetect while suspended gives wakeIrq = 1 for exactly one cycle, starting the next cycle, with no change of bus state. When not suspended, wakeIrq stays 0.
- R11: driveResume and driveReset are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| suspendBit | input | 1 | Software suspend request |
| resumeBit | input | 1 | Software resume request |
| resetBit | input | 1 | Software bus-reset request |
| xferBusy | input | 1 | A transaction is in progress |
| msTick | input | 1 | One-cycle pulse every millisecond |
| wakeDetect | input | 1 | Remote wake-up seen on the bus |
| schedEnable | output | 1 | Enable for frame counter and scheduler |
| sofEnable | output | 1 | Enable for start-of-frame packets |
| driveResume | output | 1 | Request resume signalling on the bus |
| driveReset | output | 1 | Request reset signalling on the bus |
| wakeIrq | output | 1 | One-cycle remote wake-up interrupt |
| timingViolation | output | 1 | Last signalling interval was shorter than MIN_MS |

## Verification
The bench builds the block with MIN_MS = 3 instead of the default 20. This makes an interval that just meets the minimum, and one that falls a tick short, only a few cycles long. The random episodes can then cross the violation threshold in both directions many times. The same setting lets the counter's saturation be exercised with intervals of up to five ticks. Busy lengths of up to four cycles exercise the deferred suspend.

// File: rtl/host_bus_seq_pkg.sv
package host_bus_seq_pkg;

  typedef enum logic [1:0] {
    ST_RUN      = 2'd0,
    ST_SUSPEND  = 2'd1,
    ST_RESUMING = 2'd2,
    ST_RESETTING= 2'd3
  } busState_t;

  typedef struct packed {
    logic startInterval;
    logic countEn;
    logic endInterval;
    logic suspended;
  } seqStrobes_t;

endpackage

// File: rtl/host_bus_seq_ctrl.sv
module host_bus_seq_ctrl
  import host_bus_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        suspendBit,
  input  logic        resumeBit,
  input  logic        resetBit,
  input  logic        xferBusy,
  output seqStrobes_t strobes,
  output logic        running,
  output logic        sigResume,
  output logic        sigReset
);

  busState_t state, nextState;
  logic      inSignal, nextSignal;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_RUN: begin
        if (resetBit)                      nextState = ST_RESETTING;
        else if (suspendBit && !xferBusy)  nextState = ST_SUSPEND;
      end
      ST_SUSPEND: begin
        if (resetBit)                      nextState = ST_RESETTING;
        else if (resumeBit && !suspendBit) nextState = ST_RESUMING;
      end
      ST_RESUMING: begin
        if (resetBit)                      nextState = ST_RESETTING;
        else if (!resumeBit)               nextState = ST_RUN;
      end
      ST_RESETTING: begin
        if (!resetBit)                     nextState = ST_RUN;
      end
      default:                             nextState = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_RUN;
    else       state <= nextState;
  end

  assign inSignal   = (state == ST_RESUMING) || (state == ST_RESETTING);
  assign nextSignal = (nextState == ST_RESUMING) || (nextState == ST_RESETTING);

  always_comb begin
    strobes.startInterval = nextSignal && (nextState != state);
    strobes.countEn       = inSignal && (nextState == state);
    strobes.endInterval   = inSignal && (nextState == ST_RUN);
    strobes.suspended     = (state == ST_SUSPEND);
  end

  assign running   = (state == ST_RUN);
  assign sigResume = (state == ST_RESUMING);
  assign sigReset  = (state == ST_RESETTING);

endmodule

// File: rtl/host_bus_seq_dp.sv
module host_bus_seq_dp
  import host_bus_seq_pkg::*;
#(
  parameter int MIN_MS = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  seqStrobes_t strobes,
  input  logic        msTick,
  input  logic        wakeDetect,
  output logic        wakeIrq,
  output logic        timingViolation
);

  localparam int CNT_W = $clog2(MIN_MS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_MS);

  logic [CNT_W-1:0] msCount;
  logic             wakePrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      msCount <= '0;
    end else if (strobes.startInterval) begin
      msCount <= '0;
    end else if (strobes.countEn && msTick && (msCount < CNT_MAX)) begin
      msCount <= msCount + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                    timingViolation <= 1'b0;
    else if (strobes.endInterval) timingViolation <= (msCount < CNT_MAX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wakePrev <= 1'b0;
      wakeIrq  <= 1'b0;
    end else begin
      wakePrev <= wakeDetect;
      wakeIrq  <= strobes.suspended && wakeDetect && !wakePrev;
    end
  end

endmodule

// File: rtl/host_bus_seq.sv
module host_bus_seq
  import host_bus_seq_pkg::*;
#(
  parameter int MIN_MS = 20
) (
  input  logic clk,
  input  logic rstN,
  input  logic suspendBit,
  input  logic resumeBit,
  input  logic resetBit,
  input  logic xferBusy,
  input  logic msTick,
  input  logic wakeDetect,
  output logic schedEnable,
  output logic sofEnable,
  output logic driveResume,
  output logic driveReset,
  output logic wakeIrq,
  output logic timingViolation
);

  seqStrobes_t strobes;
  logic        running;

  host_bus_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .suspendBit (suspendBit),
    .resumeBit  (resumeBit),
    .resetBit   (resetBit),
    .xferBusy   (xferBusy),
    .strobes    (strobes),
    .running    (running),
    .sigResume  (driveResume),
    .sigReset   (driveReset)
  );

  host_bus_seq_dp #(.MIN_MS(MIN_MS)) u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .strobes         (strobes),
    .msTick          (msTick),
    .wakeDetect      (wakeDetect),
    .wakeIrq         (wakeIrq),
    .timingViolation (timingViolation)
  );

  assign schedEnable = running;
  assign sofEnable   = running;

endmodule

// File: rtl/host_bus_seq_checker.sv
module host_bus_seq_checker (
  input logic clk,
  input logic rstN,
  input logic resumeBit,
  input logic resetBit,
  input logic xferBusy,
  input logic schedEnable,
  input logic driveResume,
  input logic driveReset,
  input logic wakeIrq,
  input logic timingViolation
);

  assert_reset_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    resetBit |=> driveReset);

  assert_one_drive_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(driveReset && driveResume));

  assert_suspend_waits_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(schedEnable) && !driveReset) |-> !$past(xferBusy));

  assert_irq_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    wakeIrq |=> !wakeIrq);

  assert_restart_after_sig_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(schedEnable) |-> $past(driveResume || driveReset));

  assert_resume_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    (driveResume && !resumeBit && !resetBit) |=> schedEnable);

  assert_flag_on_end_R9: assert property (@(posedge clk) disable iff (!rstN)
    (timingViolation != $past(timingViolation)) |-> $past(driveResume || driveReset));

endmodule

bind host_bus_seq host_bus_seq_checker u_checker (
  .clk             (clk),
  .rstN            (rstN),
  .resumeBit       (resumeBit),
  .resetBit        (resetBit),
  .xferBusy        (xferBusy),
  .schedEnable     (schedEnable),
  .driveResume     (driveResume),
  .driveReset      (driveReset),
  .wakeIrq         (wakeIrq),
  .timingViolation (timingViolation)
);

// File: tb/host_bus_seq_test.sv
`timescale 1ns/1ps
module host_bus_seq_test;

  localparam int MIN_MS = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic suspendBit = 1'b0, resumeBit = 1'b0, resetBit = 1'b0;
  logic xferBusy = 1'b0, msTick = 1'b0, wakeDetect = 1'b0;
  logic schedEnable, sofEnable, driveResume, driveReset, wakeIrq, timingViolation;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  host_bus_seq #(.MIN_MS(MIN_MS)) uut (
    .clk(clk), .rstN(rstN), .suspendBit(suspendBit), .resumeBit(resumeBit),
    .resetBit(resetBit), .xferBusy(xferBusy), .msTick(msTick), .wakeDetect(wakeDetect),
    .schedEnable(schedEnable), .sofEnable(sofEnable), .driveResume(driveResume),
    .driveReset(driveReset), .wakeIrq(wakeIrq), .timingViolation(timingViolation)
  );

  function automatic logic expViolation(int ticks);
    return (ticks < MIN_MS);
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chkRunning(input logic exp, input string tag);
    chk(schedEnable, exp, {tag, " schedEnable"});
    chk(sofEnable, exp, {tag, " sofEnable"});
  endtask

  task automatic giveTicks(input int n);
    for (int i = 0; i < n; i++) begin
      msTick = 1'b1; step();
      msTick = 1'b0; step();
    end
  endtask

  // R2 / R3: suspend, optionally behind a busy transaction
  task automatic doSuspend(input int busy);
    suspendBit = 1'b1;
    xferBusy = (busy > 0);
    step();
    for (int i = 0; i < busy; i++) begin
      chkRunning(1'b1, "R3 busy hold");
      if (i == busy - 1) xferBusy = 1'b0;
      step();
    end
    if (busy == 0) chkRunning(1'b0, "R2 suspend");
    else           chkRunning(1'b0, "R3 stop after busy");
  endtask

  // R5 / R6 / R9
  task automatic doResume(input int ticks);
    resumeBit = 1'b1; suspendBit = 1'b0;
    step();
    chk(driveResume, 1'b1, "R5 resume drive");
    chk(schedEnable, 1'b0, "R5 sched off");
    giveTicks(ticks);
    chk(driveResume, 1'b1, "R5 resume held");
    resumeBit = 1'b0;
    step();
    chk(driveResume, 1'b0, "R6 resume end");
    chkRunning(1'b1, "R6 restart");
    chk(timingViolation, expViolation(ticks), "R9 resume interval");
  endtask

  // R7 / R8 / R9
  task automatic doReset(input int ticks);
    resetBit = 1'b1;
    step();
    chk(driveReset, 1'b1, "R7 reset drive");
    chk(driveResume, 1'b0, "R11 exclusive");
    chk(schedEnable, 1'b0, "R7 sched off");
    giveTicks(ticks);
    chk(driveReset, 1'b1, "R7 reset held");
    resetBit = 1'b0; suspendBit = 1'b0; resumeBit = 1'b0;
    step();
    chk(driveReset, 1'b0, "R8 reset end");
    chkRunning(1'b1, "R8 restart");
    chk(timingViolation, expViolation(ticks), "R9 reset interval");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    int seedVal;
    seedVal = $urandom(32'd5739);
    repeat (3) step();
    rstN = 1'b1;
    step();
    // R1 reset state
    chkRunning(1'b1, "R1 reset");
    chk(driveResume, 1'b0, "R1 driveResume");
    chk(driveReset, 1'b0, "R1 driveReset");
    chk(wakeIrq, 1'b0, "R1 wakeIrq");
    chk(timingViolation, 1'b0, "R1 timingViolation");

    // R10 wake ignored while running
    wakeDetect = 1'b1; step();
    chk(wakeIrq, 1'b0, "R10 no irq when running");
    wakeDetect = 1'b0; step();

    doSuspend(0);
    // R4 resume bit alone while suspend still set
    resumeBit = 1'b1; step(); step();
    chkRunning(1'b0, "R4 stays suspended");
    chk(driveResume, 1'b0, "R4 no resume drive");
    resumeBit = 1'b0; step();

    // R10 wake pulse while suspended
    wakeDetect = 1'b1; step();
    chk(wakeIrq, 1'b1, "R10 irq pulse");
    chkRunning(1'b0, "R10 state kept");
    step();
    chk(wakeIrq, 1'b0, "R10 one cycle");
    wakeDetect = 1'b0; step();

    doResume(MIN_MS);        // exactly minimum
    doSuspend(3);
    doResume(MIN_MS - 1);    // one short
    doReset(MIN_MS + 2);     // saturates, clears flag
    doReset(0);

    // R7 priority: all three bits from suspended
    doSuspend(1);
    resetBit = 1'b1; resumeBit = 1'b1; suspendBit = 1'b0;
    step();
    chk(driveReset, 1'b1, "R7 priority reset");
    chk(driveResume, 1'b0, "R7 priority no resume");
    doReset(MIN_MS);

    // R7 reset preempts a pending suspend behind busy
    suspendBit = 1'b1; xferBusy = 1'b1; resetBit = 1'b1;
    step();
    chk(driveReset, 1'b1, "R7 reset over busy suspend");
    xferBusy = 1'b0;
    doReset(1);

    // constrained random episodes
    for (int ep = 0; ep < 40; ep++) begin
      int busy, ticks;
      busy  = $urandom_range(0, 4);
      ticks = $urandom_range(0, MIN_MS + 2);
      if ($urandom_range(0, 1) == 0) begin
        doSuspend(busy);
        doResume(ticks);
      end else begin
        if ($urandom_range(0, 1) == 0) doSuspend(busy);
        doReset(ticks);
      end
      repeat ($urandom_range(0, 3)) begin
        step();
        chkRunning(1'b1, "R6 running between episodes");
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule